// File: doc/BRIEF.md
# Serial-Loaded 16-Channel PWM LED Core

This block is the digital heart of a sixteen-channel constant-current LED driver. A host shifts data in serially on its own shift clock. The last stage of the shift register is brought out as a serial output, so several devices can be chained on one data line. A level-sensitive latch strobe copies the shift register into one of two storage banks. A target-select input chooses the bank: a 12-bit brightness (grayscale) value per channel, or a 6-bit current-trim (dot-correction) value per channel.

A free-running grayscale clock advances one shared 12-bit counter. Each channel's on/off enable is high while that counter is below the channel's grayscale value. The counter stops at its terminal count and does not wrap. A blank input turns every channel off and holds the counter at zero, so each release of blank starts a fresh PWM period.

The trim values leave the block as a parallel bus for an external current DAC and have no effect on PWM timing. Two digital fault inputs (open LED, over-temperature) pull an open-drain error line low. The latch, target-select and blank inputs are brought into the grayscale clock domain through two-flop synchronisers before use.

Top module: `led_pwm_core`

## Requirements
- R1: On each rising edge of `sclk` the shift register moves one place toward its MSB and `sin` enters bit 0. `sout` is the MSB, so it presents the bit shifted in 192 shift clocks earlier.
- R2: While `blank` is high every bit of `chan_on` is 0 with no clock delay, and the PWM counter is held at zero. After `blank` falls, a new PWM period starts from count zero.
- R3: With `tgt_dc` low, a latch loads the grayscale bank. Channel n takes shift-register bits [12n+11:12n], so channel 15 is sent first and each value is sent MSB first.
- R4: While `latch` is low, shifting new data changes neither bank: `dc_trim` and the PWM on-times keep their earlier values.
- R5: After `blank` is released, channel n is on for exactly G(n) grayscale clock cycles, where G(n) is its grayscale value. A value of 0 keeps the channel off.
- R6: The counter stops at 4095 and does not wrap. Over any window longer than 4096 cycles, each channel's total on-time is still G(n), and a value of 4095 gives 4095 on-cycles.
- R7: With `tgt_dc` high, a latch loads the trim bank. Channel n's 6-bit trim takes shift-register bits [6n+5:6n] and appears on `dc_trim[6n+5:6n]`. The grayscale bank and the PWM on-times are unchanged.
- R8: `err_pull_low` is 1 exactly when `fault_open` or `fault_therm` is 1.
- R9: After reset, `chan_on` is 0, `dc_trim` is 0 and `sout` is 0.
- R10: The latch is level-sensitive. While `latch` stays high, the selected bank follows further shifting, within three grayscale clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock for the serial register |
| gsclk | input | 1 | Grayscale reference clock for the PWM counter and the banks |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output (shift-register MSB) for chaining |
| tgt_dc | input | 1 | Latch target select: 0 grayscale bank, 1 trim bank |
| latch | input | 1 | Level-sensitive latch strobe |
| blank | input | 1 | Forces all channels off and clears the PWM counter |
| fault_open | input | 1 | Open-LED fault flag |
| fault_therm | input | 1 | Over-temperature fault flag |
| chan_on | output | 16 | Per-channel current-sink enable |
| dc_trim | output | 96 | Six-bit trim value per channel, channel n at [6n+5:6n] |
| err_pull_low | output | 1 | Open-drain enable: 1 drives the error line low |

## Verification
`sout` changes on the `sclk` rise that shifts the register, and the bench reads it half a shift period later. `chan_on` falls in the same cycle that `blank` rises, so that check is made 1 ns after the drive. Latch, target and blank pass through two synchronising flops, so a bank update lands on the third `gsclk` edge after the strobe. The bench holds each strobe for six cycles and then waits six more before it reads `dc_trim`. On-times are measured by counting high samples at falling edges over a 4300-cycle window. This window covers the synchroniser delay and runs past a full period, so an exact count also shows that the counter neither starts late nor wraps.

// File: rtl/ledpwm_pkg.sv
`timescale 1ns/1ps
package ledpwm_pkg;
    // bit positions inside the synchronised control vector
    localparam int unsigned SYN_LAT   = 0;
    localparam int unsigned SYN_TGT   = 1;
    localparam int unsigned SYN_BLANK = 2;
    localparam int unsigned SYN_W     = 3;

    typedef enum logic {
        TGT_GRAY = 1'b0,
        TGT_TRIM = 1'b1
    } tgt_e;
endpackage

// File: rtl/led_shift.sv
`timescale 1ns/1ps
module led_shift #(
    parameter int unsigned W = 192
) (
    input  logic         sclk,
    input  logic         rst_n,
    input  logic         sin,
    output logic [W-1:0] sr_o,
    output logic         sout
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], sin};
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sr_o = sr_q;
    assign sout = sr_q[W-1];
endmodule

// File: rtl/led_sync.sv
`timescale 1ns/1ps
module led_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/led_bank.sv
`timescale 1ns/1ps
module led_bank
    import ledpwm_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned GSW = 12,
    parameter int unsigned DCW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lat_s,
    input  tgt_e                 tgt_s,
    input  logic [NCH*GSW-1:0]   sr_i,
    output logic [NCH*GSW-1:0]   gray_o,
    output logic [NCH*DCW-1:0]   trim_o
);
    localparam int unsigned GW = NCH * GSW;
    localparam int unsigned TW = NCH * DCW;

    typedef struct packed {
        logic [GW-1:0] gray;
        logic [TW-1:0] trim;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lat_s) begin
            unique case (tgt_s)
                TGT_GRAY: st_d.gray = sr_i;
                TGT_TRIM: st_d.trim = sr_i[TW-1:0];
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;
    assign trim_o = st_q.trim;
endmodule

// File: rtl/led_pwm.sv
`timescale 1ns/1ps
module led_pwm #(
    parameter int unsigned NCH = 16,
    parameter int unsigned GSW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank_raw,
    input  logic               blank_s,
    input  logic [NCH*GSW-1:0] gray_i,
    output logic [GSW-1:0]     cnt_o,
    output logic [NCH-1:0]     chan_o
);
    localparam logic [GSW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [GSW-1:0] cnt;
    } pwm_t;

    pwm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (blank_s)                st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar ch = 0; ch < int'(NCH); ch++) begin : g_cmp
        assign chan_o[ch] = !blank_raw && !blank_s &&
                            (st_q.cnt < gray_i[ch*GSW +: GSW]);
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/led_pwm_core.sv
`timescale 1ns/1ps
module led_pwm_core
    import ledpwm_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned GSW = 12,
    parameter int unsigned DCW = 6
) (
    input  logic               sclk,
    input  logic               gsclk,
    input  logic               rst_n,
    input  logic               sin,
    output logic               sout,
    input  logic               tgt_dc,
    input  logic               latch,
    input  logic               blank,
    input  logic               fault_open,
    input  logic               fault_therm,
    output logic [NCH-1:0]     chan_on,
    output logic [NCH*DCW-1:0] dc_trim,
    output logic               err_pull_low
);
    localparam int unsigned SRW = NCH * GSW;

    logic [SRW-1:0]   sr_bits;
    logic [SYN_W-1:0] ctl_raw, ctl_s;
    logic             lat_s, blank_s;
    tgt_e             tgt_s;
    logic [SRW-1:0]   gray_flat;
    logic [GSW-1:0]   pwm_cnt;

    led_shift #(.W(SRW)) u_shift (
        .sclk (sclk),
        .rst_n(rst_n),
        .sin  (sin),
        .sr_o (sr_bits),
        .sout (sout)
    );

    always_comb begin
        ctl_raw            = '0;
        ctl_raw[SYN_LAT]   = latch;
        ctl_raw[SYN_TGT]   = tgt_dc;
        ctl_raw[SYN_BLANK] = blank;
    end

    led_sync #(.W(SYN_W), .STAGES(2)) u_sync (
        .clk  (gsclk),
        .rst_n(rst_n),
        .d_i  (ctl_raw),
        .q_o  (ctl_s)
    );

    assign lat_s   = ctl_s[SYN_LAT];
    assign blank_s = ctl_s[SYN_BLANK];
    assign tgt_s   = ctl_s[SYN_TGT] ? TGT_TRIM : TGT_GRAY;

    led_bank #(.NCH(NCH), .GSW(GSW), .DCW(DCW)) u_bank (
        .clk   (gsclk),
        .rst_n (rst_n),
        .lat_s (lat_s),
        .tgt_s (tgt_s),
        .sr_i  (sr_bits),
        .gray_o(gray_flat),
        .trim_o(dc_trim)
    );

    led_pwm #(.NCH(NCH), .GSW(GSW)) u_pwm (
        .clk      (gsclk),
        .rst_n    (rst_n),
        .blank_raw(blank),
        .blank_s  (blank_s),
        .gray_i   (gray_flat),
        .cnt_o    (pwm_cnt),
        .chan_o   (chan_on)
    );

    assign err_pull_low = fault_open | fault_therm;
endmodule

// File: rtl/led_pwm_chk.sv
`timescale 1ns/1ps
module led_pwm_chk #(
    parameter int unsigned NCH = 16,
    parameter int unsigned GSW = 12,
    parameter int unsigned DCW = 6
) (
    input logic               gsclk,
    input logic               rst_n,
    input logic               blank,
    input logic               blank_s,
    input logic               lat_s,
    input logic               fault_open,
    input logic               fault_therm,
    input logic               err_pull_low,
    input logic [NCH-1:0]     chan_on,
    input logic [GSW-1:0]     cnt,
    input logic [NCH*GSW-1:0] gray_flat,
    input logic [NCH*DCW-1:0] dc_trim
);
    localparam logic [GSW-1:0] CMAX = '1;

    assert_blank_off_R2: assert property (@(posedge gsclk) disable iff (!rst_n)
        blank |-> (chan_on == '0));

    assert_blank_clear_R2: assert property (@(posedge gsclk) disable iff (!rst_n)
        blank_s |=> (cnt == '0));

    assert_hold_banks_R4: assert property (@(posedge gsclk) disable iff (!rst_n)
        !lat_s |=> ($stable(gray_flat) && $stable(dc_trim)));

    assert_off_stays_off_R5: assert property (@(posedge gsclk) disable iff (!rst_n)
        (!blank && !blank_s && !lat_s && cnt != '0 && chan_on == '0) |=> (chan_on == '0));

    assert_no_wrap_R6: assert property (@(posedge gsclk) disable iff (!rst_n)
        (!blank_s && cnt == CMAX) |=> (cnt == CMAX));

    assert_err_R8: assert property (@(posedge gsclk) disable iff (!rst_n)
        err_pull_low == (fault_open | fault_therm));
endmodule

bind led_pwm_core led_pwm_chk #(.NCH(NCH), .GSW(GSW), .DCW(DCW)) u_chk (
    .gsclk       (gsclk),
    .rst_n       (rst_n),
    .blank       (blank),
    .blank_s     (blank_s),
    .lat_s       (lat_s),
    .fault_open  (fault_open),
    .fault_therm (fault_therm),
    .err_pull_low(err_pull_low),
    .chan_on     (chan_on),
    .cnt         (pwm_cnt),
    .gray_flat   (gray_flat),
    .dc_trim     (dc_trim)
);

// File: tb/sim_led_pwm_core.sv
`timescale 1ns/1ps
module sim_led_pwm_core;
    localparam int NCH = 16;
    localparam int GSW = 12;
    localparam int DCW = 6;
    localparam int SRW = NCH * GSW;
    localparam int TW  = NCH * DCW;
    localparam int WIN = 4300;

    // each row: {base, step}; channel n grayscale = (base + n*step) mod 4096
    localparam logic [23:0] VEC [4] = '{
        {12'd0,    12'd0},
        {12'd4095, 12'd0},
        {12'd1,    12'd256},
        {12'd100,  12'd37}
    };

    logic clk = 1'b0;
    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic sin = 1'b0, tgt_dc = 1'b0, latch = 1'b0, blank = 1'b1;
    logic fault_open = 1'b0, fault_therm = 1'b0;
    logic sout, err_pull_low;
    logic [NCH-1:0] chan_on;
    logic [TW-1:0]  dc_trim;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    led_pwm_core #(.NCH(NCH), .GSW(GSW), .DCW(DCW)) u0 (
        .sclk(sclk), .gsclk(clk), .rst_n(rst_n), .sin(sin), .sout(sout),
        .tgt_dc(tgt_dc), .latch(latch), .blank(blank),
        .fault_open(fault_open), .fault_therm(fault_therm),
        .chan_on(chan_on), .dc_trim(dc_trim), .err_pull_low(err_pull_low)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [SRW-1:0] act, input logic [SRW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sin = b;
        #20 sclk = 1'b1;
        #20 sclk = 1'b0;
    endtask

    // word bit (N-1) is sent first
    task automatic shift_word(input logic [SRW-1:0] w, input int nbits);
        for (int k = nbits - 1; k >= 0; k--) shift_bit(w[k]);
    endtask

    task automatic strobe(input logic to_trim);
        tgt_dc = to_trim;
        repeat (4) @(posedge clk);
        latch = 1'b1;
        repeat (6) @(posedge clk);
        latch = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    function automatic logic [SRW-1:0] gray_word(input logic [11:0] base, input logic [11:0] step);
        logic [SRW-1:0] w = '0;
        for (int ch = 0; ch < NCH; ch++) w[ch*GSW +: GSW] = base + 12'(ch) * step;
        return w;
    endfunction

    // count on-cycles per channel after blank release, compare to grayscale values
    task automatic measure(input logic [SRW-1:0] g, input string tag);
        int on_cnt [NCH];
        blank = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        blank = 1'b0;
        for (int ch = 0; ch < NCH; ch++) on_cnt[ch] = 0;
        repeat (WIN) begin
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) if (chan_on[ch]) on_cnt[ch]++;
        end
        for (int ch = 0; ch < NCH; ch++)
            check(on_cnt[ch] == int'(g[ch*GSW +: GSW]), tag,
                  SRW'(on_cnt[ch]), SRW'(g[ch*GSW +: GSW]));
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [SRW-1:0] cur_gray, word, trim_w, trim2;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(chan_on == '0, "R9 chan_on", SRW'(chan_on), '0);
        check(dc_trim == '0, "R9 dc_trim", SRW'(dc_trim), '0);
        check(sout == 1'b0, "R9 sout", SRW'(sout), '0);

        // R8: error flag truth table
        for (int f = 0; f < 4; f++) begin
            fault_open = f[0]; fault_therm = f[1];
            #1 check(err_pull_low == (f != 0), "R8 err_pull_low", SRW'(err_pull_low), SRW'(f != 0));
        end
        fault_open = 1'b0; fault_therm = 1'b0;

        // R3 R5 R6: vector table of grayscale patterns
        for (int v = 0; v < 4; v++) begin
            word = gray_word(VEC[v][23:12], VEC[v][11:0]);
            shift_word(word, SRW);
            // R1: MSB of register is the first bit sent
            check(sout == word[SRW-1], "R1 sout first bit", SRW'(sout), SRW'(word[SRW-1]));
            strobe(1'b0);
            measure(word, v == 1 ? "R6 terminal count" : "R3 R5 on-time");
            cur_gray = word;
        end

        // R1: chaining, extra bits push the earlier stream out
        for (int k = 1; k <= 4; k++) begin
            shift_bit(1'b0);
            #5 check(sout == cur_gray[SRW-1-k], "R1 sout chain", SRW'(sout), SRW'(cur_gray[SRW-1-k]));
        end
        // restore register contents to current grayscale bank image
        shift_word(cur_gray, SRW);

        // R2: blank mid-period forces off at once, then restarts the period
        @(negedge clk) blank = 1'b0;
        repeat (300) @(negedge clk);
        blank = 1'b1;
        #1 check(chan_on == '0, "R2 immediate off", SRW'(chan_on), '0);
        repeat (10) @(negedge clk);
        check(chan_on == '0, "R2 held off", SRW'(chan_on), '0);
        measure(cur_gray, "R2 restart");

        // R7: trim load; grayscale timing unchanged
        trim_w = '0;
        for (int ch = 0; ch < NCH; ch++) trim_w[ch*DCW +: DCW] = 6'(ch * 5 + 3);
        shift_word(trim_w, TW);
        strobe(1'b1);
        check(dc_trim == trim_w[TW-1:0], "R7 trim bus", SRW'(dc_trim), trim_w);
        measure(cur_gray, "R7 gray unchanged");

        // R4: shift without latch changes nothing
        shift_word(gray_word(12'd7, 12'd3), SRW);
        repeat (10) @(negedge clk);
        check(dc_trim == trim_w[TW-1:0], "R4 trim held", SRW'(dc_trim), trim_w);
        measure(cur_gray, "R4 gray held");

        // R10: level-sensitive tracking while latch stays high
        tgt_dc = 1'b1;
        repeat (4) @(posedge clk);
        latch = 1'b1;
        trim2 = '0;
        for (int ch = 0; ch < NCH; ch++) trim2[ch*DCW +: DCW] = 6'(63 - ch * 2);
        shift_word(trim2, TW);
        repeat (6) @(negedge clk);
        check(dc_trim == trim2[TW-1:0], "R10 tracks while high", SRW'(dc_trim), trim2);
        latch = 1'b0;
        repeat (6) @(negedge clk);
        shift_word('0, TW);
        repeat (10) @(negedge clk);
        check(dc_trim == trim2[TW-1:0], "R4 R10 hold after low", SRW'(dc_trim), trim2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule